// File: doc/BRIEF.md
# UART Receiver with Multiprocessor Addressing

This block is the receive half of an asynchronous serial port. It resynchronises the serial line into the system clock domain and detects the falling edge of a start bit. Each bit is decided by a three-sample majority vote, and the block assembles 8-bit or 9-bit characters. Finished characters go into a one-deep receive data register. Software reads that register, together with a status register and a control register, through a small register bus with a combinational read path.

Bit timing comes from an external baud enable tick. A bit normally lasts 16 ticks and lasts 8 ticks when the double-speed option is on. The status register holds a receive-complete flag, a framing-error flag and an overrun flag. The overrun flag is buffered, so it appears only after the character that survived the overrun has been read.

In multiprocessor mode the receiver discards every frame whose ninth bit is clear, so only address frames reach software. The block also gates three interrupt requests: its own receive-complete flag, and two flags that come from an external transmitter, transmit-complete and data-register-empty. Each request is gated by its enable bit and by a global interrupt enable input.

Top module: `uart_rx_mp`

## Requirements
- R1: After reset the data register reads 0x00, the status register reads 0x00, and the control register reads 0x80. In the control register every writable bit is 0 and bit 7 is the read-only received ninth bit, which resets to 1.
- R2: A frame is one low start bit, then data bits LSB first, then one stop bit. A frame is received when the receiver is enabled (control bit 0), 8-bit mode is selected (control bit 1 = 0) and one bit lasts 16 baud ticks. Its byte then appears at address 0 and status bit 0 (receive complete) sets.
- R3: With control bit 1 set the frame carries nine data bits and the ninth is shown in control bit 7. In 8-bit mode control bit 7 shows the first stop-bit value.
- R4: With control bit 2 set, one bit lasts 8 baud ticks instead of 16.
- R5: Status bit 2 (framing error) takes the inverse of the sampled stop bit, and only when a character is moved into the data register. A later good transfer clears it.
- R6: A bus read of address 0 clears status bit 0.
- R7: A frame that completes while status bit 0 is still set is lost and an overrun becomes pending. Status bit 1 stays 0 until address 0 is read, then reads 1. The next character moved into the data register clears it.
- R8: With control bit 3 set, any frame whose ninth bit is 0 is dropped: no flag changes and the data register keeps its value. Frames whose ninth bit is 1 are accepted.
- R9: While control bit 0 is clear no frame is received and status bits 0 to 2 cannot set. Clearing control bit 0 leaves flags that are already set unchanged.
- R10: A low pulse that samples high by majority at the start-bit centre is ignored.
- R11: The three interrupt outputs are separate. The receive interrupt is raised by status bit 0 with control bit 4 set. The transmit-complete interrupt is raised by input `tx_done_i` with control bit 5 set. The data-register-empty interrupt is raised by input `tx_empty_i` with control bit 6 set. Each is raised only while `glb_irq_en_i` is high.
- R12: Status bits 7 to 3 always read 0, and writes to the status address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| baud_tick_i | input | 1 | One-cycle oversampling enable pulse |
| bus_addr_i | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (side effects on address 0) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data |
| glb_irq_en_i | input | 1 | Global interrupt enable |
| tx_done_i | input | 1 | Transmit-complete flag from the transmitter |
| tx_empty_i | input | 1 | Data-register-empty flag from the transmitter |
| irq_rx_o | output | 1 | Receive-complete interrupt request |
| irq_txc_o | output | 1 | Transmit-complete interrupt request |
| irq_dre_o | output | 1 | Data-register-empty interrupt request |

## Verification
The assertions assume that the bus issues at most one strobe per cycle. They also assume that the control bits selecting double speed and character length change only while the line is idle, because a mid-frame change would alter the bit period. The bench writes the control register only between frames, after the line has been high for at least two bit periods. It drives the baud tick on every second clock. Each serial bit is held for a whole number of tick periods, so every majority sample falls well inside its bit.

// File: rtl/uart_rx_mp_pkg.sv
// Package: shared types and register-map constants of the receiver.
// Assumes: included first in compile order.
package uart_rx_mp_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    localparam logic [1:0] ADDR_DATA   = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    localparam int CB_EN    = 0;
    localparam int CB_NINE  = 1;
    localparam int CB_DBL   = 2;
    localparam int CB_MP    = 3;
    localparam int CB_IERX  = 4;
    localparam int CB_IETXC = 5;
    localparam int CB_IEDRE = 6;
    localparam int CTRL_W   = 7;
endpackage

// File: rtl/uart_rx_mp_sync.sv
// Synchroniser: brings the asynchronous serial line into the clock domain.
// Assumes: line idles high, so the flops reset to 1.
module uart_rx_mp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_mp_sampler.sv
// Sampler: start detection, three-sample majority vote per bit and frame
// assembly. Emits a one-cycle valid pulse with the byte, ninth bit and stop.
// Assumes: OSR is a multiple of 4; dbl_i and nine_i are stable during a frame.
module uart_rx_mp_sampler
    import uart_rx_mp_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       tick_i,
    input  logic       dbl_i,
    input  logic       nine_i,
    input  logic       rx_i,
    output logic       valid_o,
    output logic [7:0] byte_o,
    output logic       ninth_o,
    output logic       stop_ok_o
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST_N = CW'(OSR - 1);
    localparam logic [CW-1:0] LAST_D = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] MID_N  = CW'(OSR / 2);
    localparam logic [CW-1:0] MID_D  = CW'(OSR / 4);

    rx_state_t     state_q;
    logic [CW-1:0] cnt_q;
    logic [3:0]    bitcnt_q;
    logic [8:0]    sh_q;
    logic          v0_q, v1_q;

    logic [CW-1:0] last_idx, mid_idx, mid_lo, mid_hi;
    logic [3:0]    nbits;
    logic          vote;

    // Per-mode sample positions and character length.
    always_comb begin
        last_idx = dbl_i ? LAST_D : LAST_N;
        mid_idx  = dbl_i ? MID_D : MID_N;
        mid_lo   = mid_idx - 1'b1;
        mid_hi   = mid_idx + 1'b1;
        nbits    = nine_i ? 4'd9 : 4'd8;
        vote     = (v0_q & v1_q) | (v0_q & rx_i) | (v1_q & rx_i);
    end

    // Frame state machine driven by the baud tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            bitcnt_q  <= '0;
            sh_q      <= '0;
            v0_q      <= 1'b1;
            v1_q      <= 1'b1;
            valid_o   <= 1'b0;
            byte_o    <= '0;
            ninth_o   <= 1'b1;
            stop_ok_o <= 1'b1;
        end else begin
            valid_o <= 1'b0;
            if (!enable_i) begin
                state_q <= RX_IDLE;
            end else if (tick_i) begin
                if (state_q == RX_IDLE) begin
                    if (!rx_i) begin
                        state_q <= RX_START;
                        cnt_q   <= {{(CW-1){1'b0}}, 1'b1};
                    end
                end else begin
                    if (cnt_q == mid_lo) v0_q <= rx_i;
                    if (cnt_q == mid_idx) v1_q <= rx_i;
                    if (cnt_q == mid_hi) begin
                        case (state_q)
                            RX_START: if (vote) state_q <= RX_IDLE;
                            RX_DATA: begin
                                sh_q     <= {vote, sh_q[8:1]};
                                bitcnt_q <= bitcnt_q + 4'd1;
                            end
                            RX_STOP: begin
                                valid_o   <= 1'b1;
                                byte_o    <= nine_i ? sh_q[7:0] : sh_q[8:1];
                                ninth_o   <= nine_i ? sh_q[8] : vote;
                                stop_ok_o <= vote;
                                state_q   <= RX_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt_q == last_idx) begin
                        cnt_q <= '0;
                        if (state_q == RX_START) begin
                            state_q  <= RX_DATA;
                            bitcnt_q <= '0;
                        end else if (state_q == RX_DATA && bitcnt_q == nbits) begin
                            state_q <= RX_STOP;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_mp_regs.sv
// Register file: data register, buffered overrun, framing and receive flags,
// multiprocessor filtering, control bits and interrupt gating.
// Assumes: one bus strobe per cycle; read data is combinational.
module uart_rx_mp_regs
    import uart_rx_mp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fr_valid_i,
    input  logic [7:0] fr_byte_i,
    input  logic       fr_ninth_i,
    input  logic       fr_stop_ok_i,
    input  logic [1:0] bus_addr_i,
    input  logic       bus_wr_i,
    input  logic       bus_rd_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    input  logic       glb_irq_en_i,
    input  logic       tx_done_i,
    input  logic       tx_empty_i,
    output logic       irq_rx_o,
    output logic       irq_txc_o,
    output logic       irq_dre_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic       rxc_o,
    output logic       ovr_o,
    output logic       fe_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [7:0]        data_q;
    logic              ninth_q, rxc_q, ovr_q, fe_q, ovr_pend_q;
    logic              rd_data, accept, room, transfer, lost;
    logic              unused_wdata;

    assign unused_wdata = bus_wdata_i[7];

    // Decide whether a finished frame is taken, dropped or lost.
    always_comb begin
        rd_data  = bus_rd_i && (bus_addr_i == ADDR_DATA);
        accept   = fr_valid_i && ctrl_q[CB_EN] && !(ctrl_q[CB_MP] && !fr_ninth_i);
        room     = !rxc_q || rd_data;
        transfer = accept && room;
        lost     = accept && !room;
    end

    // Control register write port.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    ctrl_q <= '0;
        else if (bus_wr_i && bus_addr_i == ADDR_CTRL)  ctrl_q <= bus_wdata_i[CTRL_W-1:0];
    end

    // Receive data, ninth bit and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q     <= '0;
            ninth_q    <= 1'b1;
            rxc_q      <= 1'b0;
            ovr_q      <= 1'b0;
            fe_q       <= 1'b0;
            ovr_pend_q <= 1'b0;
        end else if (transfer) begin
            data_q     <= fr_byte_i;
            ninth_q    <= fr_ninth_i;
            fe_q       <= !fr_stop_ok_i;
            rxc_q      <= 1'b1;
            ovr_q      <= 1'b0;
            ovr_pend_q <= 1'b0;
        end else begin
            if (rd_data) begin
                rxc_q <= 1'b0;
                if (ovr_pend_q && ctrl_q[CB_EN]) begin
                    ovr_q      <= 1'b1;
                    ovr_pend_q <= 1'b0;
                end
            end
            if (lost) ovr_pend_q <= 1'b1;
        end
    end

    // Combinational read mux.
    always_comb begin
        case (bus_addr_i)
            ADDR_DATA:   bus_rdata_o = data_q;
            ADDR_STATUS: bus_rdata_o = {5'b0, fe_q, ovr_q, rxc_q};
            ADDR_CTRL:   bus_rdata_o = {ninth_q, ctrl_q};
            default:     bus_rdata_o = 8'h00;
        endcase
    end

    // Interrupt gating.
    always_comb begin
        irq_rx_o  = glb_irq_en_i && ctrl_q[CB_IERX]  && rxc_q;
        irq_txc_o = glb_irq_en_i && ctrl_q[CB_IETXC] && tx_done_i;
        irq_dre_o = glb_irq_en_i && ctrl_q[CB_IEDRE] && tx_empty_i;
    end

    assign ctrl_o = ctrl_q;
    assign rxc_o  = rxc_q;
    assign ovr_o  = ovr_q;
    assign fe_o   = fe_q;
endmodule

// File: rtl/uart_rx_mp.sv
// Top: synchroniser, bit sampler and register file of the UART receiver.
// Assumes: baud_tick_i pulses at OSR times the nominal bit rate.
module uart_rx_mp
    import uart_rx_mp_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd_i,
    input  logic       baud_tick_i,
    input  logic [1:0] bus_addr_i,
    input  logic       bus_wr_i,
    input  logic       bus_rd_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    input  logic       glb_irq_en_i,
    input  logic       tx_done_i,
    input  logic       tx_empty_i,
    output logic       irq_rx_o,
    output logic       irq_txc_o,
    output logic       irq_dre_o
);
    logic              rx_sync;
    logic              fr_valid, fr_ninth, fr_stop_ok;
    logic [7:0]        fr_byte;
    logic [CTRL_W-1:0] ctrl_w;
    logic              rxc_w, ovr_w, fe_w;

    uart_rx_mp_sync #(.STAGES(SYNC_DEPTH)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(rxd_i), .sync_o(rx_sync)
    );

    uart_rx_mp_sampler #(.OSR(OSR)) samp_i (
        .clk(clk), .rst_n(rst_n), .enable_i(ctrl_w[CB_EN]), .tick_i(baud_tick_i),
        .dbl_i(ctrl_w[CB_DBL]), .nine_i(ctrl_w[CB_NINE]), .rx_i(rx_sync),
        .valid_o(fr_valid), .byte_o(fr_byte), .ninth_o(fr_ninth), .stop_ok_o(fr_stop_ok)
    );

    uart_rx_mp_regs regs_i (
        .clk(clk), .rst_n(rst_n),
        .fr_valid_i(fr_valid), .fr_byte_i(fr_byte), .fr_ninth_i(fr_ninth),
        .fr_stop_ok_i(fr_stop_ok),
        .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .glb_irq_en_i(glb_irq_en_i), .tx_done_i(tx_done_i), .tx_empty_i(tx_empty_i),
        .irq_rx_o(irq_rx_o), .irq_txc_o(irq_txc_o), .irq_dre_o(irq_dre_o),
        .ctrl_o(ctrl_w), .rxc_o(rxc_w), .ovr_o(ovr_w), .fe_o(fe_w)
    );
endmodule

// File: rtl/uart_rx_mp_chk.sv
// Checker: temporal properties of the receiver, bound to the top module.
// Assumes: at most one bus strobe per cycle.
module uart_rx_mp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr_i,
    input logic       bus_rd_i,
    input logic       bus_wr_i,
    input logic [7:0] bus_rdata_o,
    input logic       glb_irq_en_i,
    input logic       irq_rx_o,
    input logic       irq_txc_o,
    input logic       irq_dre_o,
    input logic       rx_en,
    input logic       fr_valid,
    input logic       rxc,
    input logic       ovr,
    input logic       fe
);
    assert_no_set_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rxc) |=> !rxc);

    assert_fe_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !fe) |=> !fe);

    assert_read_clears_rxc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == 2'd0 && !fr_valid) |=> !rxc);

    assert_ovr_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(bus_rd_i && bus_addr_i == 2'd0));

    assert_rxc_from_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxc) |-> $past(fr_valid));

    assert_irq_global_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_irq_en_i |-> !(irq_rx_o || irq_txc_o || irq_dre_o));

    assert_status_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == 2'd1) |-> (bus_rdata_o[7:3] == 5'b0));

    assert_fe_only_on_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe) |-> $past(fr_valid));
endmodule

bind uart_rx_mp uart_rx_mp_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_rd_i(bus_rd_i),
    .bus_wr_i(bus_wr_i), .bus_rdata_o(bus_rdata_o), .glb_irq_en_i(glb_irq_en_i),
    .irq_rx_o(irq_rx_o), .irq_txc_o(irq_txc_o), .irq_dre_o(irq_dre_o),
    .rx_en(ctrl_w[0]), .fr_valid(fr_valid), .rxc(rxc_w), .ovr(ovr_w), .fe(fe_w)
);

// File: tb/uart_rx_mp_tb_top.sv
module uart_rx_mp_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       glb = 1'b0, txd = 1'b0, txe = 1'b0;
    logic       irq_rx, irq_txc, irq_dre;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10ns clk = ~clk;

    // Baud tick on every second clock.
    always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

    uart_rx_mp dut_i (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .baud_tick_i(tick),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .glb_irq_en_i(glb), .tx_done_i(txd), .tx_empty_i(txe),
        .irq_rx_o(irq_rx), .irq_txc_o(irq_txc), .irq_dre_o(irq_dre)
    );

    // Vector: ctrl[34:27] frame[26:18] stop[17] status[16:9] data[8:1] ninth[0]
    localparam int NV = 8;
    localparam logic [34:0] VEC [NV] = '{
        {8'h01, 9'h0A5, 1'b1, 8'h01, 8'hA5, 1'b1},
        {8'h01, 9'h03C, 1'b0, 8'h05, 8'h3C, 1'b0},
        {8'h03, 9'h155, 1'b1, 8'h01, 8'h55, 1'b1},
        {8'h05, 9'h05A, 1'b1, 8'h01, 8'h5A, 1'b1},
        {8'h0B, 9'h033, 1'b1, 8'h00, 8'h00, 1'b0},
        {8'h0B, 9'h1C2, 1'b1, 8'h01, 8'hC2, 1'b1},
        {8'h07, 9'h0F0, 1'b0, 8'h05, 8'hF0, 1'b0},
        {8'h09, 9'h077, 1'b1, 8'h01, 8'h77, 1'b1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1ns d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic hold_line(input logic v, input int clks);
        rxd = v;
        repeat (clks) @(negedge clk);
    endtask

    // Sends start, data LSB first, stop, then two idle bit periods.
    task automatic send_frame(input logic nine, input logic dbl, input logic [8:0] d,
                              input logic stop);
        int bc;
        bc = dbl ? 16 : 32;
        @(negedge clk);
        hold_line(1'b0, bc);
        for (int i = 0; i < (nine ? 9 : 8); i++) hold_line(d[i], bc);
        hold_line(stop, bc);
        hold_line(1'b1, 2 * bc);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_read(2'd0, v); check("R1 data reset", v, 8'h00);
        bus_read(2'd1, v); check("R1 status reset", v, 8'h00);
        bus_read(2'd2, v); check("R1 control reset", v, 8'h80);
        check("R11 irq reset", {5'b0, irq_rx, irq_txc, irq_dre}, 8'h00);

        // Vector table: R2 R3 R4 R5 R8
        for (int k = 0; k < NV; k++) begin
            c = VEC[k][34:27];
            bus_write(2'd2, c);
            send_frame(c[1], c[2], VEC[k][26:18], VEC[k][17]);
            bus_read(2'd1, v); check($sformatf("R2/R5/R8 status vec%0d", k), v, VEC[k][16:9]);
            if (VEC[k][9]) begin
                bus_read(2'd2, v);
                check($sformatf("R3 ninth vec%0d", k), {7'b0, v[7]}, {7'b0, VEC[k][0]});
                bus_read(2'd0, v); check($sformatf("R2/R4 data vec%0d", k), v, VEC[k][8:1]);
                bus_read(2'd1, v); check($sformatf("R6 rxc cleared vec%0d", k), v[0] ? 8'h01 : 8'h00, 8'h00);
            end else begin
                bus_read(2'd0, v); check($sformatf("R8 data kept vec%0d", k), v, 8'h5A);
            end
        end

        // R7 buffered overrun
        bus_write(2'd2, 8'h01);
        send_frame(1'b0, 1'b0, 9'h011, 1'b1);
        send_frame(1'b0, 1'b0, 9'h022, 1'b1);
        bus_read(2'd1, v); check("R7 overrun hidden", v, 8'h01);
        bus_read(2'd0, v); check("R7 held char kept", v, 8'h11);
        bus_read(2'd1, v); check("R7 overrun visible", v, 8'h02);
        send_frame(1'b0, 1'b0, 9'h033, 1'b1);
        bus_read(2'd1, v); check("R7 overrun cleared", v, 8'h01);
        bus_read(2'd0, v); check("R7 next char", v, 8'h33);

        // R9 disabled receiver
        bus_write(2'd2, 8'h00);
        send_frame(1'b0, 1'b0, 9'h0E7, 1'b0);
        bus_read(2'd1, v); check("R9 no flags when off", v, 8'h00);
        bus_read(2'd0, v); check("R9 data unchanged", v, 8'h33);
        bus_write(2'd2, 8'h01);
        send_frame(1'b0, 1'b0, 9'h044, 1'b0);
        bus_write(2'd2, 8'h00);
        bus_read(2'd1, v); check("R9 flags frozen", v, 8'h05);
        bus_read(2'd0, v); check("R9 data", v, 8'h44);

        // R12 status write ignored, reserved bits zero
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, v); check("R12 status reserved", v, 8'h04);

        // R10 start glitch
        bus_write(2'd2, 8'h01);
        @(negedge clk);
        hold_line(1'b0, 4);
        hold_line(1'b1, 400);
        bus_read(2'd1, v); check("R10 glitch ignored", {7'b0, v[0]}, 8'h00);
        send_frame(1'b0, 1'b0, 9'h081, 1'b1);
        bus_read(2'd0, v); check("R10 frame after glitch", v, 8'h81);

        // R11 interrupts
        bus_write(2'd2, 8'h71);
        send_frame(1'b0, 1'b0, 9'h0C3, 1'b1);
        glb = 1'b1; txd = 1'b0; txe = 1'b0;
        @(negedge clk);
        check("R11 rx irq only", {5'b0, irq_rx, irq_txc, irq_dre}, 8'h04);
        txd = 1'b1; txe = 1'b1;
        @(negedge clk);
        check("R11 all irqs", {5'b0, irq_rx, irq_txc, irq_dre}, 8'h07);
        glb = 1'b0;
        @(negedge clk);
        check("R11 global gate", {5'b0, irq_rx, irq_txc, irq_dre}, 8'h00);
        glb = 1'b1;
        bus_write(2'd2, 8'h01);
        @(negedge clk);
        check("R11 enables off", {5'b0, irq_rx, irq_txc, irq_dre}, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule